// File: doc/BRIEF.md
# DDR3 Self-Refresh Exit Sequencer

This block brings a DDR3 device back from self-refresh. On a start request it first turns the memory clock back on. One cycle later it raises clock-enable (CKE). It then waits a programmable no-command delay. When the configuration marks the device's DLL as switched off, it reloads mode register 1. The reload uses a fixed bit layout, with the termination and drive-strength fields taken from configuration inputs.

Next it issues one auto-refresh. After that it runs three incremental calibration steps in a fixed order: write leveling, then read strobe (DQS) training, then read data-eye training. Each step is a request/done handshake with an external engine. The sequencer then settles in a ready state. In that state a separate flag tells the command scheduler whether reads and writes may go out. That flag is gated by a second programmable delay, which is counted from the cycle in which CKE rose.

The block sits between a power-management controller and the DRAM command path. The calibration engines themselves are outside it.

Top module: `sr_exit_seq`

## Requirements
- R1: After reset the block is parked with the device in self-refresh. In that state `mem_clk_en_o`, `cke_o`, `cal_req_o` and `rw_ok_o` are 0, `cmd_o` is NOP (2'd0), and `bank_o` and `addr_o` are 0. It stays parked until a start request arrives, whatever the calibration done inputs do.
- R2: A start request sampled while parked or ready sets `mem_clk_en_o` to 1 with `cke_o` still 0 in the next cycle. `cke_o` goes to 1 in the cycle after that.
- R3: Taking the first cycle with `cke_o` high as offset 0, the first command appears at offset max(`t_exit_nr_i`,1). Every cycle before that carries NOP.
- R4: If `cfg_dll_off_i` is 1, the first command is a mode-register load (`cmd_o`=2'd1) with `bank_o`=1. `addr_o` then holds: bit 0 = 1; bit 1 = drive[0]; bit 2 = term[0]; bit 5 = drive[1]; bit 6 = term[1]; bit 9 = term[2]; every other bit 0. Outside that cycle `bank_o` and `addr_o` are 0.
- R5: The auto-refresh (`cmd_o`=2'd2) is issued exactly once per sequence. It comes in the cycle right after the mode-register load, or directly at the offset of R3 when `cfg_dll_off_i` is 0.
- R6: From the cycle after the refresh, `cal_req_o` raises bit 0 (write leveling), then bit 1 (DQS training), then bit 2 (data-eye training). At most one bit is high at a time. Each bit is held until its done input is sampled high, and the next bit rises in the following cycle.
- R7: The cycle after the last done input is sampled, the block enters ready. `cke_o` and `mem_clk_en_o` stay 1 from the rise of CKE onward.
- R8: `rw_ok_o` is 1 in a cycle exactly when the block is ready and at least `t_exit_rw_i` cycles have passed since offset 0 of R3. It is 0 from the start request until then.
- R9: A start request that arrives while a sequence is in progress has no effect. CKE stays high and the command and request timing go on unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request to leave self-refresh |
| cfg_dll_off_i | input | 1 | Device DLL is disabled; selects the mode-register reload |
| cfg_term_i | input | 3 | On-die termination code for mode register 1 |
| cfg_drive_i | input | 2 | Output drive-strength code for mode register 1 |
| t_exit_nr_i | input | TW (8) | Cycles from CKE rise to the first command |
| t_exit_rw_i | input | TW (8) | Cycles from CKE rise until reads and writes may go |
| cal_done_i | input | NCAL (3) | Done per calibration step: 0 write leveling, 1 DQS, 2 data eye |
| mem_clk_en_o | output | 1 | Memory clock running |
| cke_o | output | 1 | DRAM clock-enable |
| cmd_o | output | 2 | Command: 0 NOP, 1 mode-register load, 2 auto-refresh |
| bank_o | output | BA_W (3) | Bank address of the command |
| addr_o | output | ADDR_W (16) | Address bus of the command |
| cal_req_o | output | NCAL (3) | Calibration step request, same bit order as done |
| rw_ok_o | output | 1 | Reads and writes may be issued |

## Verification
The assertions assume two things about the inputs. First, a calibration done bit is only raised while its own request is high. Second, the configuration fields are held stable from the start request until the sequence reaches ready. The mode-register check compares the command against the live DLL-disable input, so it relies on that stability. The stimulus changes configuration and timing values only while the block is ready and just before it pulses start. It raises each done bit for one cycle at a chosen delay inside the matching request window. It injects extra start pulses only while a sequence is still running.

// File: rtl/sr_exit_pkg.sv
`timescale 1ns/1ps
package sr_exit_pkg;

    typedef enum logic [2:0] {
        ST_PARK  = 3'd0,
        ST_CLKON = 3'd1,
        ST_WAIT  = 3'd2,
        ST_MRS   = 3'd3,
        ST_REF   = 3'd4,
        ST_CAL   = 3'd5,
        ST_READY = 3'd6
    } seq_st_e;

    typedef enum logic [1:0] {
        CMD_NOP = 2'd0,
        CMD_MRS = 2'd1,
        CMD_REF = 2'd2
    } dram_cmd_e;

    typedef struct packed {
        seq_st_e st;
    } seq_ctl_t;

endpackage

// File: rtl/sr_exit_dly_cnt.sv
`timescale 1ns/1ps
// Loadable down-counter. EARLY selects whether expiry is flagged at a count of
// one or below (hand-over a cycle early) or only at zero.
module sr_exit_dly_cnt #(
    parameter int W     = 8,
    parameter bit EARLY = 1'b0
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic         expire_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d.cnt = val_i;
        end else if (cnt_q.cnt != '0) begin
            cnt_d.cnt = cnt_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    generate
        if (EARLY) begin : g_early
            assign expire_o = (cnt_q.cnt[W-1:1] == '0);
        end else begin : g_exact
            assign expire_o = (cnt_q.cnt == '0);
        end
    endgenerate

    // Delay windows used for R3 and R8 shrink by one per cycle unless reloaded
    assert_count_down_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!load_i && cnt_q.cnt != '0) |=> (cnt_q.cnt == $past(cnt_q.cnt) - 1'b1));

    assert_zero_sticks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!load_i && cnt_q.cnt == '0) |=> (cnt_q.cnt == '0));

endmodule

// File: rtl/sr_exit_mr1_map.sv
`timescale 1ns/1ps
// Builds the mode-register-1 image used on the DLL-off exit path.
module sr_exit_mr1_map #(
    parameter int ADDR_W = 16
) (
    input  logic [2:0]        term_i,
    input  logic [1:0]        drive_i,
    output logic [ADDR_W-1:0] img_o
);
    localparam int TOP_USED = 9;

    always_comb begin
        img_o    = '0;
        img_o[0] = 1'b1;        // DLL off
        img_o[1] = drive_i[0];
        img_o[2] = term_i[0];
        img_o[5] = drive_i[1];
        img_o[6] = term_i[1];
        img_o[9] = term_i[2];   // everything else: buffers on, no leveling, AL 0
    end

    initial begin
        assert_width_fits_R4: assert (ADDR_W > TOP_USED)
            else $error("address bus narrower than the mode-register image");
    end

endmodule

// File: rtl/sr_exit_cal_chain.sv
`timescale 1ns/1ps
// Steps through NCAL calibration handshakes in index order.
module sr_exit_cal_chain #(
    parameter int NCAL = 3
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            go_i,
    input  logic [NCAL-1:0] done_i,
    output logic [NCAL-1:0] req_o,
    output logic            fin_o
);
    localparam int          IW   = (NCAL > 1) ? $clog2(NCAL) : 1;
    localparam logic [IW-1:0] LAST = IW'(NCAL - 1);

    typedef struct packed {
        logic          active;
        logic [IW-1:0] idx;
    } chain_st_t;

    chain_st_t ch_d, ch_q;
    logic      cur_done;

    assign cur_done = done_i[ch_q.idx];
    assign fin_o    = ch_q.active && (ch_q.idx == LAST) && cur_done;

    always_comb begin
        ch_d = ch_q;
        if (!ch_q.active) begin
            if (go_i) begin
                ch_d.active = 1'b1;
                ch_d.idx    = '0;
            end
        end else if (cur_done) begin
            if (ch_q.idx == LAST) begin
                ch_d.active = 1'b0;
                ch_d.idx    = '0;
            end else begin
                ch_d.idx = ch_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ch_q <= '0;
        end else begin
            ch_q <= ch_d;
        end
    end

    for (genvar k = 0; k < NCAL; k++) begin : g_req
        assign req_o[k] = ch_q.active && (ch_q.idx == IW'(k));
    end

    assert_one_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(req_o));

    assert_hold_until_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ch_q.active && !cur_done) |=> $stable(req_o));

    for (genvar k = 1; k < NCAL; k++) begin : g_order
        assert_step_order_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $rose(req_o[k]) |-> ($past(req_o[k-1]) && $past(done_i[k-1])));
    end

endmodule

// File: rtl/sr_exit_seq.sv
`timescale 1ns/1ps
module sr_exit_seq
    import sr_exit_pkg::*;
#(
    parameter int TW     = 8,
    parameter int ADDR_W = 16,
    parameter int BA_W   = 3,
    parameter int NCAL   = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic              cfg_dll_off_i,
    input  logic [2:0]        cfg_term_i,
    input  logic [1:0]        cfg_drive_i,
    input  logic [TW-1:0]     t_exit_nr_i,
    input  logic [TW-1:0]     t_exit_rw_i,
    input  logic [NCAL-1:0]   cal_done_i,
    output logic              mem_clk_en_o,
    output logic              cke_o,
    output logic [1:0]        cmd_o,
    output logic [BA_W-1:0]   bank_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [NCAL-1:0]   cal_req_o,
    output logic              rw_ok_o
);
    localparam logic [BA_W-1:0] MR1_BANK = BA_W'(1);

    seq_ctl_t          ctl_d, ctl_q;
    logic              dly_load;
    logic              nr_done;
    logic              rw_done;
    logic              cal_go;
    logic              cal_fin;
    logic [ADDR_W-1:0] mr1_img;

    // Both windows start in the first cycle with CKE high
    assign dly_load = (ctl_q.st == ST_CLKON);
    assign cal_go   = (ctl_q.st == ST_REF);

    sr_exit_dly_cnt #(.W(TW), .EARLY(1'b1)) u_nr_cnt (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .load_i   (dly_load),
        .val_i    (t_exit_nr_i),
        .expire_o (nr_done)
    );

    sr_exit_dly_cnt #(.W(TW), .EARLY(1'b0)) u_rw_cnt (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .load_i   (dly_load),
        .val_i    (t_exit_rw_i),
        .expire_o (rw_done)
    );

    sr_exit_mr1_map #(.ADDR_W(ADDR_W)) u_mr1 (
        .term_i  (cfg_term_i),
        .drive_i (cfg_drive_i),
        .img_o   (mr1_img)
    );

    sr_exit_cal_chain #(.NCAL(NCAL)) u_cal (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .go_i   (cal_go),
        .done_i (cal_done_i),
        .req_o  (cal_req_o),
        .fin_o  (cal_fin)
    );

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.st)
            ST_PARK, ST_READY: if (start_i) ctl_d.st = ST_CLKON;
            ST_CLKON:          ctl_d.st = ST_WAIT;
            ST_WAIT:           if (nr_done) ctl_d.st = cfg_dll_off_i ? ST_MRS : ST_REF;
            ST_MRS:            ctl_d.st = ST_REF;
            ST_REF:            ctl_d.st = ST_CAL;
            ST_CAL:            if (cal_fin) ctl_d.st = ST_READY;
            default:           ctl_d.st = ST_PARK;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ctl_q <= '{st: ST_PARK};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        mem_clk_en_o = (ctl_q.st != ST_PARK);
        cke_o        = !(ctl_q.st inside {ST_PARK, ST_CLKON});
        cmd_o        = CMD_NOP;
        bank_o       = '0;
        addr_o       = '0;
        if (ctl_q.st == ST_MRS) begin
            cmd_o  = CMD_MRS;
            bank_o = MR1_BANK;
            addr_o = mr1_img;
        end else if (ctl_q.st == ST_REF) begin
            cmd_o = CMD_REF;
        end
        rw_ok_o = (ctl_q.st == ST_READY) && rw_done;
    end

    assert_clock_before_cke_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(cke_o) |-> $past(mem_clk_en_o));

    assert_cmd_needs_cke_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_o != CMD_NOP) |-> (cke_o && $past(cke_o)));

    assert_mrs_only_dll_off_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_o == CMD_MRS) |-> cfg_dll_off_i);

    assert_ref_after_mrs_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_o == CMD_MRS) |=> (cmd_o == CMD_REF));

    assert_cal_after_ref_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_o == CMD_REF) |=> cal_req_o[0]);

    assert_rw_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rw_ok_o |-> (cke_o && mem_clk_en_o && (cal_req_o == '0) && (cmd_o == CMD_NOP)));

    assert_start_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((ctl_q.st inside {ST_CLKON, ST_WAIT, ST_MRS, ST_REF, ST_CAL}) && start_i)
        |=> (ctl_q.st != ST_CLKON));

endmodule

// File: tb/sr_exit_seq_tb.sv
`timescale 1ns/1ps
module sr_exit_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        dll_off = 1'b0;
    logic [2:0]  term = '0;
    logic [1:0]  drive = '0;
    logic [7:0]  t_nr = '0;
    logic [7:0]  t_rw = '0;
    logic [2:0]  done = '0;
    logic        clk_en;
    logic        cke;
    logic [1:0]  cmd;
    logic [2:0]  bank;
    logic [15:0] addr;
    logic [2:0]  req;
    logic        rw_ok;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    sr_exit_seq u_dut (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .start_i       (start),
        .cfg_dll_off_i (dll_off),
        .cfg_term_i    (term),
        .cfg_drive_i   (drive),
        .t_exit_nr_i   (t_nr),
        .t_exit_rw_i   (t_rw),
        .cal_done_i    (done),
        .mem_clk_en_o  (clk_en),
        .cke_o         (cke),
        .cmd_o         (cmd),
        .bank_o        (bank),
        .addr_o        (addr),
        .cal_req_o     (req),
        .rw_ok_o       (rw_ok)
    );

    function automatic logic [15:0] mr1_exp(logic [2:0] t, logic [1:0] d);
        logic [15:0] a = '0;
        a[0] = 1'b1;
        a[1] = d[0];
        a[2] = t[0];
        a[5] = d[1];
        a[6] = t[1];
        a[9] = t[2];
        return a;
    endfunction

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic run_exit(int n, int m, bit dll, logic [2:0] tv, logic [1:0] dv,
                            int d0, int d1, int d2, bit noisy);
        int w, r, s0, s1, s2, tr, last;
        bit prev_start;
        dll_off = dll; term = tv; drive = dv;
        t_nr = 8'(n); t_rw = 8'(m);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // cycle after start sampled: clocks on, CKE low
        chk("R2 clk_en on", 32'(clk_en), 32'd1);
        chk("R2 cke still low", 32'(cke), 32'd0);
        chk("R8 rw blocked", 32'(rw_ok), 32'd0);
        w    = imax(n, 1);
        r    = dll ? w + 1 : w;
        s0   = r + 1;
        s1   = s0 + d0 + 1;
        s2   = s1 + d1 + 1;
        tr   = s2 + d2 + 1;
        last = imax(tr, m) + 3;
        prev_start = 1'b0;
        for (int off = 0; off <= last; off++) begin
            logic [1:0]  e_cmd;
            logic [2:0]  e_req;
            logic [15:0] e_addr;
            logic [2:0]  e_bank;
            @(negedge clk);
            done[0] = (off == s0 + d0);
            done[1] = (off == s1 + d1);
            done[2] = (off == s2 + d2);
            if (prev_start) chk("R9 stray start ignored", 32'(cke), 32'd1);
            start = noisy && (off < tr) && (($urandom % 3) == 0);
            prev_start = start;
            e_cmd  = 2'd0;
            e_addr = '0;
            e_bank = '0;
            if (dll && off == w) begin
                e_cmd = 2'd1; e_addr = mr1_exp(tv, dv); e_bank = 3'd1;
            end else if (off == r) begin
                e_cmd = 2'd2;
            end
            e_req = '0;
            if (off >= s0 && off < s1) e_req = 3'b001;
            if (off >= s1 && off < s2) e_req = 3'b010;
            if (off >= s2 && off < tr) e_req = 3'b100;
            if (e_cmd == 2'd1)      chk("R4 mode-register load", 32'(cmd), 32'(e_cmd));
            else if (e_cmd == 2'd2) chk("R5 refresh", 32'(cmd), 32'(e_cmd));
            else                    chk("R3 nop", 32'(cmd), 32'(e_cmd));
            chk("R4 address", 32'(addr), 32'(e_addr));
            chk("R4 bank", 32'(bank), 32'(e_bank));
            chk("R6 calibration request", 32'(req), 32'(e_req));
            chk("R7 cke high", 32'(cke), 32'd1);
            chk("R7 clock on", 32'(clk_en), 32'd1);
            chk("R8 rw_ok", 32'(rw_ok), 32'((off >= tr) && (off >= m)));
        end
        start = 1'b0;
        done  = '0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: parked after reset, done pulses do nothing
        for (int i = 0; i < 6; i++) begin
            done = 3'(i);
            @(negedge clk);
            chk("R1 clk_en", 32'(clk_en), 32'd0);
            chk("R1 cke", 32'(cke), 32'd0);
            chk("R1 cmd", 32'(cmd), 32'd0);
            chk("R1 req", 32'(req), 32'd0);
            chk("R1 rw_ok", 32'(rw_ok), 32'd0);
            chk("R1 addr", 32'({bank, addr}), 32'd0);
        end
        done = '0;
        @(negedge clk);
        // directed corners
        run_exit(0, 0, 1'b1, 3'd5, 2'd2, 0, 0, 0, 1'b0);
        run_exit(1, 60, 1'b0, 3'd0, 2'd0, 0, 1, 0, 1'b0);
        run_exit(6, 10, 1'b1, 3'd7, 2'd3, 3, 1, 4, 1'b1);
        run_exit(3, 0, 1'b1, 3'd2, 2'd1, 2, 0, 2, 1'b1);
        run_exit(2, 12, 1'b0, 3'd4, 2'd1, 0, 0, 0, 1'b1);
        // random mix
        for (int k = 0; k < 25; k++) begin
            run_exit(int'($urandom % 8), int'($urandom % 46), bit'($urandom % 2),
                     3'($urandom), 2'($urandom),
                     int'($urandom % 5), int'($urandom % 5), int'($urandom % 5),
                     bit'($urandom % 2));
        end
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL R6 watchdog expired: actual hung expected sequence end");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule